// File: doc/BRIEF.md
# Linear Photodiode Array Readout Sequencer

This block is the digital control logic of a photodiode line sensor built from two equal sections that share one clock. A start bit sampled high on a rising edge places a one-hot token on the first pixel of a section; the token then moves one pixel per clock. While the token rests on a pixel, that pixel is selected for the section's analog output, and the output-enable models the tri-state analog pin. When the token moves off a pixel, a clear strobe naming that pixel resets its integrator. An end-of-section flag is high while the last pixel of a section is selected.

A static mode input chooses between two independent chains of `NPIX` pixels each, and one long chain of `2*NPIX` pixels. In the long chain, the end flag of the first section starts the second section, and the second section's own start pin has no effect. A start that arrives while the chain it would begin is still busy is rejected and flagged for one cycle. The clock edge that moves the token off the final pixel is needed to return the chain to idle.

Top module: `lsq_readout`

## Requirements
- R1: While `rst_n` is sampled low on a rising edge, both sections go idle after that edge: select-enables, end flags, clear strobes and error flags are all 0.
- R2: A start sampled high on an edge while its chain is idle makes that section's select-enable 1 with pixel index 0 (pixels are numbered from 0) in the cycle after that edge.
- R3: While a section is selected and not on its last pixel, the index rises by exactly one on every edge, and the select-enable stays 1.
- R4: A section's end flag is 1 exactly when that section selects pixel `NPIX-1`.
- R5: The edge after the last pixel of a section turns that section's select-enable off. In a chain of N pixels, this is edge N+1 counted from the start edge.
- R6: After each edge that moves the token off pixel k, the clear strobe is 1 with clear index k for one cycle. Otherwise the strobe is 0.
- R7: A start sampled on the terminating edge N+1 is rejected and flagged. A start on edge N+2 is accepted.
- R8: A start sampled while its chain is busy sets the section's error flag in the next cycle and does not disturb the running sequence. This includes a start held high for a second edge.
- R9: With `chain_en` = 0, the two sections run independently from `start_a` and `start_b`.
- R10: With `chain_en` = 1, section B begins pixel 0 on the edge after section A selects its last pixel. The two sections are never selected together. `start_a` is refused until section B has finished.
- R11: With `chain_en` = 1, `start_b` is ignored: section B's outputs and error flag do not respond to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chain_en | input | 1 | Static mode select: 1 joins the sections into one chain, 0 keeps them independent |
| start_a | input | 1 | Start bit for section A |
| start_b | input | 1 | Start bit for section B (used only when `chain_en` = 0) |
| sel_en_a | output | 1 | Section A output enable (models the tri-state analog pin) |
| sel_idx_a | output | IW | Pixel of section A that drives its output |
| end_a | output | 1 | Section A is on its last pixel |
| clr_a | output | 1 | Integrator clear strobe, section A |
| clr_idx_a | output | IW | Pixel of section A being cleared |
| err_a | output | 1 | Start rejected on section A |
| sel_en_b | output | 1 | Section B output enable |
| sel_idx_b | output | IW | Pixel of section B that drives its output |
| end_b | output | 1 | Section B is on its last pixel |
| clr_b | output | 1 | Integrator clear strobe, section B |
| clr_idx_b | output | IW | Pixel of section B being cleared |
| err_b | output | 1 | Start rejected on section B |

## Verification
Every output is one register away from the inputs. The select state, end flag, clear strobe and error flag caused by the inputs sampled on one edge are all due in the cycle after that edge. The handoff from section A to section B lands exactly one edge after A's last pixel. The driver applies inputs on the falling edge and pushes the expected outputs for the coming rising edge into a queue. The monitor pops that entry a quarter period after the rising edge and compares each field under its requirement. Pixel indices are compared only while their enable or strobe is expected high.

// File: rtl/lsq_pkg.sv
// Package: shared mode encoding and default geometry of the readout sequencer.
// Assumes: two sections per device; pixel count per section is a parameter.
package lsq_pkg;
    localparam int unsigned NPIX_DEFAULT = 448;
    localparam int unsigned NUM_SEC      = 2;

    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_CHAIN = 1'b1
    } lsq_mode_e;
endpackage

// File: rtl/lsq_token_walker.sv
// Module: one section's token position. The position is held as a counter
// (0 = idle, 1..NPIX = selected pixel + 1) instead of an NPIX-bit shift register.
// Assumes: start is sampled on the rising edge; hold_off marks a busy
// downstream section that must finish first (used in chain mode).
module lsq_token_walker #(
    parameter int unsigned NPIX = lsq_pkg::NPIX_DEFAULT,
    parameter int unsigned IW   = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          hold_off,
    output logic          en,
    output logic [IW-1:0] idx,
    output logic          last,
    output logic          err
);
    localparam int unsigned PW = $clog2(NPIX + 1);
    localparam logic [PW-1:0] POS_LAST = PW'(NPIX);

    logic [PW-1:0] pos;
    logic          busy;

    assign busy = (pos != '0) || hold_off;

    // Purpose: advance the token, retire it after the last pixel, accept idle starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (pos != '0) begin
            pos <= (pos == POS_LAST) ? '0 : pos + 1'b1;
        end else if (start && !hold_off) begin
            pos <= PW'(1);
        end
    end

    // Purpose: flag a start that arrives while the chain is still busy.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= start && busy;
    end

    // Purpose: decode the position into select outputs.
    always_comb begin
        en   = (pos != '0);
        idx  = IW'(pos - 1'b1);
        last = (pos == POS_LAST);
    end

    // R3: the token advances one pixel per clock.
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !last) |=> (en && idx == $past(idx) + IW'(1)));

    // R5: the edge after the last pixel returns the section to idle.
    a_r5_terminate: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !en);

    // R2: a new sequence always begins on pixel 0.
    a_r2_first_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (idx == '0));

    // R8: a start seen while selected is flagged on the next cycle.
    a_r8_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (start && en) |=> err);
endmodule

// File: rtl/lsq_clear_strobe.sv
// Module: integrator clear strobe. A pixel is cleared in the cycle after the
// token leaves it, so the strobe is the selection delayed by one edge.
// Assumes: the token never rests on one pixel for more than one clock.
module lsq_clear_strobe #(
    parameter int unsigned IW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_en,
    input  logic [IW-1:0] sel_idx,
    output logic          clr,
    output logic [IW-1:0] clr_idx
);
    // Purpose: record the pixel the token is leaving on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr     <= 1'b0;
            clr_idx <= '0;
        end else begin
            clr     <= sel_en;
            clr_idx <= sel_idx;
        end
    end
endmodule

// File: rtl/lsq_readout.sv
// Module: two-section readout sequencer top. Routes the start bits according
// to the mode: split (independent sections) or chain (A's end flag starts B).
// Assumes: chain_en changes only while rst_n is low.
module lsq_readout #(
    parameter int unsigned NPIX = lsq_pkg::NPIX_DEFAULT,
    parameter int unsigned IW   = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chain_en,
    input  logic          start_a,
    input  logic          start_b,
    output logic          sel_en_a,
    output logic [IW-1:0] sel_idx_a,
    output logic          end_a,
    output logic          clr_a,
    output logic [IW-1:0] clr_idx_a,
    output logic          err_a,
    output logic          sel_en_b,
    output logic [IW-1:0] sel_idx_b,
    output logic          end_b,
    output logic          clr_b,
    output logic [IW-1:0] clr_idx_b,
    output logic          err_b
);
    import lsq_pkg::*;

    localparam int unsigned NS = NUM_SEC;

    lsq_mode_e     mode;
    logic [NS-1:0] sec_start, sec_hold, sec_en, sec_last, sec_clr, sec_err;
    logic [IW-1:0] sec_idx  [NS];
    logic [IW-1:0] sec_cidx [NS];

    // Purpose: steer the start bits and the busy hold-off for the selected mode.
    always_comb begin
        mode         = lsq_mode_e'(chain_en);
        sec_start[0] = start_a;
        sec_hold[0]  = (mode == MODE_CHAIN) && sec_en[1];
        sec_start[1] = (mode == MODE_CHAIN) ? sec_last[0] : start_b;
        sec_hold[1]  = 1'b0;
    end

    for (genvar s = 0; s < NS; s++) begin : g_sec
        lsq_token_walker #(.NPIX(NPIX), .IW(IW)) walker_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (sec_start[s]),
            .hold_off (sec_hold[s]),
            .en       (sec_en[s]),
            .idx      (sec_idx[s]),
            .last     (sec_last[s]),
            .err      (sec_err[s])
        );

        lsq_clear_strobe #(.IW(IW)) clear_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_en  (sec_en[s]),
            .sel_idx (sec_idx[s]),
            .clr     (sec_clr[s]),
            .clr_idx (sec_cidx[s])
        );

        // R6: when a section goes idle, the last pixel is the one cleared.
        a_r6_final_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sec_en[s]) |-> (sec_clr[s] && sec_cidx[s] == IW'(NPIX - 1)));

        // R4: the end flag accompanies only the final pixel.
        a_r4_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
            sec_last[s] |-> (sec_en[s] && sec_idx[s] == IW'(NPIX - 1)));
    end

    // R10: in chain mode the two sections are never selected together.
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        chain_en |-> !(sec_en[0] && sec_en[1]));

    // R10: in chain mode section B starts right after A's last pixel.
    a_r10_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_en && sec_last[0]) |=> (sec_en[1] && sec_idx[1] == '0));

    // R11: in chain mode section B never reports a rejected start.
    a_r11_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        chain_en |=> !sec_err[1]);

    assign sel_en_a  = sec_en[0];
    assign sel_idx_a = sec_idx[0];
    assign end_a     = sec_last[0];
    assign clr_a     = sec_clr[0];
    assign clr_idx_a = sec_cidx[0];
    assign err_a     = sec_err[0];
    assign sel_en_b  = sec_en[1];
    assign sel_idx_b = sec_idx[1];
    assign end_b     = sec_last[1];
    assign clr_b     = sec_clr[1];
    assign clr_idx_b = sec_cidx[1];
    assign err_b     = sec_err[1];
endmodule

// File: tb/lsq_readout_tb_top.sv
// Bench: scoreboard. The driver applies inputs on the falling edge and queues
// the outputs expected after the next rising edge. The monitor pops and compares.
module lsq_readout_tb_top;
    localparam int N          = 448;
    localparam int IW         = $clog2(N);
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chain_en = 1'b0;
    logic          start_a = 1'b0;
    logic          start_b = 1'b0;
    logic          sel_en_a, end_a, clr_a, err_a;
    logic          sel_en_b, end_b, clr_b, err_b;
    logic [IW-1:0] sel_idx_a, clr_idx_a, sel_idx_b, clr_idx_b;

    lsq_readout #(.NPIX(N), .IW(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .chain_en(chain_en),
        .start_a(start_a), .start_b(start_b),
        .sel_en_a(sel_en_a), .sel_idx_a(sel_idx_a), .end_a(end_a),
        .clr_a(clr_a), .clr_idx_a(clr_idx_a), .err_a(err_a),
        .sel_en_b(sel_en_b), .sel_idx_b(sel_idx_b), .end_b(end_b),
        .clr_b(clr_b), .clr_idx_b(clr_idx_b), .err_b(err_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit    en;
        int    idx;
        bit    so;
        bit    clr;
        int    cidx;
        bit    err;
        string ten;
        string terr;
    } sec_exp_t;

    typedef struct {
        sec_exp_t s0;
        sec_exp_t s1;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   mpos[2] = '{0, 0};
    bit   mode = 1'b0;
    bit   done = 1'b0;

    task automatic chk(string tag, string what, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, expv, $time);
        end
    endtask

    // Reference: expected outputs after the coming edge, from the requirements.
    task automatic step(bit sa, bit sb, bit rst = 1'b0);
        exp_t e;
        int   np[2];
        @(negedge clk);
        rst_n    = !rst;
        chain_en = mode;
        start_a  = sa;
        start_b  = sb;
        if (rst) begin
            e.s0 = '{0, 0, 0, 0, 0, 0, "R1", "R1"};
            e.s1 = '{0, 0, 0, 0, 0, 0, "R1", "R1"};
            mpos = '{0, 0};
        end else begin
            for (int s = 0; s < 2; s++) begin
                sec_exp_t x;
                bit st, hold, busy;
                st   = (s == 0) ? sa : (mode ? (mpos[0] == N) : sb);
                hold = (s == 0) && mode && (mpos[1] != 0);
                busy = (mpos[s] != 0) || hold;
                x.err = st && busy;
                if (mpos[s] == N || (s == 0 && mode && mpos[1] == N)) x.terr = "R7";
                else if (s == 1 && mode)                               x.terr = "R11";
                else                                                   x.terr = "R8";
                x.clr  = (mpos[s] != 0);
                x.cidx = mpos[s] - 1;
                if (mpos[s] != 0)    np[s] = (mpos[s] == N) ? 0 : mpos[s] + 1;
                else if (st && !hold) np[s] = 1;
                else                  np[s] = 0;
                x.en  = (np[s] != 0);
                x.idx = np[s] - 1;
                x.so  = (np[s] == N);
                if (s == 1)                          x.ten = mode ? (sb ? "R11" : "R10") : "R9";
                else if (mpos[s] == 0 && np[s] == 1) x.ten = "R2";
                else if (mpos[s] == N)               x.ten = "R5";
                else                                 x.ten = "R3";
                if (s == 0) e.s0 = x; else e.s1 = x;
            end
            mpos = np;
        end
        q.push_back(e);
    endtask

    task automatic cmp_sec(sec_exp_t x, logic en, logic [IW-1:0] idx, logic so,
                           logic clr, logic [IW-1:0] cidx, logic err, string nm);
        chk(x.ten, {nm, " sel_en"}, int'(en), int'(x.en));
        if (x.en) chk(x.ten, {nm, " sel_idx"}, int'(idx), x.idx);
        chk((x.ten == "R1") ? "R1" : "R4", {nm, " end"}, int'(so), int'(x.so));
        chk((x.ten == "R1") ? "R1" : "R6", {nm, " clr"}, int'(clr), int'(x.clr));
        if (x.clr) chk("R6", {nm, " clr_idx"}, int'(cidx), x.cidx);
        chk(x.terr, {nm, " err"}, int'(err), int'(x.err));
    endtask

    // Monitor: compare a quarter period after each rising edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp_sec(e.s0, sel_en_a, sel_idx_a, end_a, clr_a, clr_idx_a, err_a, "A");
            cmp_sec(e.s1, sel_en_b, sel_idx_b, end_b, clr_b, clr_idx_b, err_b, "B");
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, split mode.
        mode = 1'b0;
        repeat (3) step(0, 0, 1);
        // R2, R9: start A, then B a few cycles later.
        step(1, 0);
        repeat (4) step(0, 0);
        step(0, 1);
        // R8: start on a busy section.
        step(1, 0);
        repeat (3) step(0, 0);
        step(0, 1);
        // R3, R4, R5, R6: run A to its last pixel.
        while (mpos[0] != N) step(0, 0);
        // R7: start on the terminating edge is rejected, the next edge accepts.
        step(1, 0);
        step(1, 0);
        // R8: start held for a second edge.
        step(1, 0);
        while (mpos[0] != 0 || mpos[1] != 0) step(0, 0);
        step(0, 0);

        // R10, R11: chain mode.
        mode = 1'b1;
        repeat (2) step(0, 0, 1);
        step(1, 0);
        step(0, 1);
        repeat (10) step(0, 0);
        step(0, 1);
        while (mpos[0] != N) step(0, 0);
        step(0, 1);
        step(1, 0);
        repeat (20) step(0, 0);
        step(0, 1);
        while (mpos[1] != N) step(0, 0);
        step(1, 0);
        step(1, 0);
        repeat (6) step(0, 0);
        step(0, 1);
        repeat (3) step(0, 0);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule